// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block sits on a two-wire open-drain bus as a target and behaves like a small serial EEPROM of 8192 bytes. It uses two-byte word addressing. The memory is arranged as 256 pages of 32 bytes, and it is addressed one byte at a time. Both bus lines pass through a synchroniser. Edge detectors then find the START and STOP conditions and the SCL edges, and a state machine sequences the transaction. The block never drives SDA high. Its only bus output is an enable that pulls SDA low, used for acknowledges and for read data.

A controller writes by sending the device address with the direction bit clear, then a high address byte, a low address byte and any number of data bytes. A write burst stays inside the current 32-byte page. A controller reads by first setting the address the same way, then issuing a repeated START and the device address with the direction bit set. It then clocks out bytes until it answers one with NACK. Reads step through the whole array.

The states are as follows:
- IDLE: the block ignores the bus.
- DEV: the address byte is received.
- AHI and ALO: the two address bytes are received.
- WDATA: write data is received.
- RDATA: read data is sent.

The transitions are as follows:
- START takes any state to DEV.
- STOP takes any state to IDLE.
- DEV goes to AHI on a matching write address, to RDATA on a matching read address, and to IDLE on a mismatch.
- AHI goes to ALO.
- ALO goes to WDATA.
- WDATA stays in WDATA.
- RDATA goes to IDLE when the controller sends NACK.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_oe` is 0. An SDA fall while SCL is high (START) begins a new address byte from any state and releases SDA.
- R2: The byte after START is a 7-bit device address followed by a direction bit in the LSB (0 = write, 1 = read). The default device address is 7'b1010000 (first byte 8'hA0 for write, 8'hA1 for read). On a match the target holds SDA low through the 9th SCL clock. It also acknowledges every address and write-data byte that follows.
- R3: A non-matching device address gets no acknowledge. Every later byte is then ignored, also without acknowledge, until the next START.
- R4: In a write, the first byte after the device address supplies address bits 12:8 from its bits 4:0; its bits 7:5 are ignored. The second byte supplies address bits 7:0. Each data byte that follows is stored at the current address.
- R5: During a write burst the address advances only in bits 4:0, so it wraps inside the current 32-byte page. Bytes in other pages are unchanged.
- R6: A random read sets the address with a write-direction header and then issues a repeated START with the read address byte. The target then returns the stored byte, MSB first, each bit driven while SCL is low.
- R7: A sequential read advances the address by one after each byte across the whole array, wrapping from 8191 to 0.
- R8: When the controller answers a read byte with NACK (SDA high on the 9th clock), the target stops driving and stays off the bus until the next START.
- R9: An SDA rise while SCL is high (STOP) returns the target to IDLE. Bytes clocked afterwards without a START are not acknowledged.
- R10: `sda_oe` changes only while SCL is low, apart from the release caused by START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL as seen on the bus |
| sda_in | input | 1 | SDA as seen on the bus (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Every response follows an SCL edge by exactly three clocks: two synchroniser stages plus the edge-detect register. An acknowledge or read data bit therefore appears on `sda_oe` three clocks after the SCL fall that opens its bit time. A START or STOP takes effect on the state three clocks after the SDA edge. The bench holds every bus phase for ten clocks and reads SDA five clocks into each SCL high period, well after each result is due and well before the next fall. The address sweep covers all 128 device addresses. The stored image is computed arithmetically in the bench, including the in-page wrap and the wrap of the array end.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA
    } tgt_state_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_p    <= scl_pipe[SYNC_STAGES-1];
            sda_p    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // SDA edges count as conditions only when SCL is high on both samples
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1010000,
    parameter int         ADDR_W   = 13,
    parameter int         PAGE_W   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    localparam int HI_W = ADDR_W - 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    tgt_state_t        state, next_st;
    logic [3:0]        bit_cnt;
    logic              in_ack;
    logic [7:0]        rx_byte, tx_byte, mem_rdata;
    logic [ADDR_W-1:0] ptr, page_next;
    logic              rx_state, byte_done, dev_match, ack_now, mem_we;
    logic [2:0]        tx_idx;

    i2c_line_sampler #(.SYNC_STAGES(2)) u_samp (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
        .clk(clk), .we(mem_we), .addr(ptr), .wdata(rx_byte), .rdata(mem_rdata)
    );

    assign rx_state  = (state == ST_DEV) || (state == ST_AHI) ||
                       (state == ST_ALO) || (state == ST_WDATA);
    assign byte_done = scl_fall && rx_state && !in_ack && (bit_cnt == 4'd8);
    assign dev_match = (rx_byte[7:1] == DEV_ADDR);
    assign ack_now   = (state != ST_DEV) || dev_match;
    assign mem_we    = byte_done && (state == ST_WDATA);
    assign page_next = {ptr[ADDR_W-1:PAGE_W], PAGE_W'(ptr[PAGE_W-1:0] + 1'b1)};
    assign tx_idx    = 3'(4'd7 - bit_cnt);

    always_comb begin
        next_st = state;
        unique case (state)
            ST_DEV:           next_st = dev_match ? (rx_byte[0] ? ST_RDATA : ST_AHI) : ST_IDLE;
            ST_AHI:           next_st = ST_ALO;
            ST_ALO, ST_WDATA: next_st = ST_WDATA;
            default:          next_st = state;
        endcase
    end

    // state register, counters, shift registers and address pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            rx_byte <= '0;
            tx_byte <= '0;
            ptr     <= '0;
        end else if (start_det) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
                    if (in_ack) begin
                        if (scl_fall) begin
                            in_ack  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end else if (scl_rise && bit_cnt < 4'd8) begin
                        rx_byte <= {rx_byte[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        state  <= next_st;
                        in_ack <= ack_now;
                        if (state == ST_AHI)        ptr[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
                        else if (state == ST_ALO)   ptr[7:0] <= rx_byte;
                        else if (state == ST_WDATA) ptr <= page_next;
                    end
                end
                ST_RDATA: begin
                    if (in_ack) begin
                        if (scl_fall) begin
                            tx_byte <= mem_rdata;
                            bit_cnt <= '0;
                            in_ack  <= 1'b0;
                        end
                    end else if (scl_rise) begin
                        if (bit_cnt < 4'd8)       bit_cnt <= bit_cnt + 4'd1;
                        else if (bit_cnt == 4'd8) begin
                            if (sda_s) state <= ST_IDLE;
                            else       bit_cnt <= 4'd9;
                        end
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) ptr <= ptr + 1'b1;
                        else if (bit_cnt == 4'd9) begin
                            tx_byte <= mem_rdata;
                            bit_cnt <= '0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // open-drain output: changes only on SCL falls, START or STOP
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
        end else if (start_det || stop_det) begin
            sda_oe <= 1'b0;
        end else if (scl_fall) begin
            if (byte_done)                sda_oe <= ack_now;
            else if (in_ack)              sda_oe <= (state == ST_RDATA) ? ~mem_rdata[7] : 1'b0;
            else if (state == ST_RDATA) begin
                if (bit_cnt == 4'd8)      sda_oe <= 1'b0;
                else if (bit_cnt == 4'd9) sda_oe <= ~mem_rdata[7];
                else                      sda_oe <= ~tx_byte[tx_idx];
            end
        end
    end
endmodule

// File: rtl/eeprom_tgt_checker.sv
module eeprom_tgt_checker
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       start_det,
    input logic       stop_det,
    input logic       in_ack,
    input tgt_state_t state
);
    assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!sda_oe && state == ST_DEV));

    assert_ack_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && state != ST_RDATA) |-> in_ack);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));
endmodule

bind i2c_eeprom_target eeprom_tgt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .start_det(start_det), .stop_det(stop_det), .in_ack(in_ack), .state(state)
);

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic csda = 1'b1;
    logic sda_oe;
    wire  sda_line = csda & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int glitches = 0;
    bit finished = 1'b0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;
    logic [7:0] model [0:8191];

    always #10 clk = ~clk;

    i2c_eeprom_target u_i2c_eeprom_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    // R10 monitor: the drive may not move while SCL is held high
    always @(negedge clk) begin
        if (rst_n && scl && prev_scl && (sda_oe !== prev_oe)) glitches++;
        prev_scl = scl;
        prev_oe  = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        csda = 1'b1; scl = 1'b1; wait_q();
        csda = 1'b0; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_rstart();
        csda = 1'b1; wait_q();
        scl = 1'b1; wait_q();
        csda = 1'b0; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        csda = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        csda = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            csda = b[i]; wait_q();
            scl = 1'b1; wait_q();
            scl = 1'b0;
        end
        wait_q();
        csda = 1'b1; wait_q();
        scl = 1'b1;
        repeat (Q/2) @(negedge clk);
        acked = ~sda_line;
        repeat (Q/2) @(negedge clk);
        scl = 1'b0; wait_q();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        csda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl = 1'b1;
            repeat (Q/2) @(negedge clk);
            b[i] = sda_line;
            repeat (Q/2) @(negedge clk);
            scl = 1'b0;
        end
        csda = give_ack ? 1'b0 : 1'b1; wait_q();
        scl = 1'b1; wait_q();
        scl = 1'b0;
        csda = 1'b1;
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 37) & 255);
    endfunction

    // R4 / R5: header plus n data bytes; model follows the in-page wrap
    task automatic page_write(input int hi, input int lo, input int n, input int seed);
        bit a;
        int addr;
        addr = ((hi & 31) << 8) | lo;
        bus_start();
        send_byte(8'hA0, a); chk("R2 write header ack", a, 1);
        send_byte(8'(hi), a); chk("R4 high address ack", a, 1);
        send_byte(8'(lo), a); chk("R4 low address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(pat(seed, i), a); chk("R4 data ack", a, 1);
            model[(addr & ~31) | ((addr + i) & 31)] = pat(seed, i);
        end
        bus_stop();
    endtask

    task automatic seq_read(input int hi, input int lo, input int n, input string req);
        bit a;
        int addr;
        logic [7:0] got;
        addr = ((hi & 31) << 8) | lo;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'(hi), a);
        send_byte(8'(lo), a);
        bus_rstart();
        send_byte(8'hA1, a); chk("R6 read header ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, got);
            chk(req, got, model[(addr + i) & 8191]);
        end
        bus_stop();
    endtask

    initial begin
        bit a;
        int lows;
        logic [7:0] got;
        repeat (5) @(negedge clk);
        chk("R1 reset sda_oe", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 / R3: sweep every device address
        for (int d = 0; d < 128; d++) begin
            bus_start();
            send_byte(8'(d << 1), a);
            chk((d == 'h50) ? "R2 match ack" : "R3 mismatch no ack", a, (d == 'h50) ? 1 : 0);
            bus_stop();
        end

        // R3: later bytes ignored after a mismatch
        bus_start();
        send_byte(8'hA2, a); chk("R3 mismatch no ack", a, 0);
        send_byte(8'h00, a); chk("R3 ignored byte", a, 0);
        send_byte(8'hA0, a); chk("R3 ignored byte", a, 0);
        bus_stop();

        // R4 / R6: byte write with upper high-address bits set, then random read
        page_write('hF2, 'h34, 1, 'hA5);
        seq_read('h12, 'h34, 1, "R6 random read data");

        // R5: page write of 35 bytes from offset 7 of page 5, next page preserved
        page_write('h00, 'hC0, 1, 'h3C);
        page_write('h00, 'hA7, 35, 11);
        seq_read('h00, 'hA0, 33, "R5 page image");

        // R7: sequential read across the end of the array
        page_write('h1F, 'hFE, 2, 'h11);
        page_write('h00, 'h00, 2, 'h33);
        seq_read('h1F, 'hFE, 4, "R7 wrap read");

        // R8: NACK ends output
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        bus_rstart();
        send_byte(8'hA1, a);
        recv_byte(1'b0, got);
        chk("R8 byte before NACK", got, model[0]);
        lows = 0;
        for (int i = 0; i < 9; i++) begin
            wait_q(); scl = 1'b1;
            repeat (Q/2) @(negedge clk);
            if (!sda_line) lows++;
            repeat (Q/2) @(negedge clk);
            scl = 1'b0;
        end
        wait_q();
        chk("R8 quiet after NACK", lows, 0);
        bus_stop();

        // R9: no acknowledge after STOP without a new START
        send_byte(8'hA0, a); chk("R9 ignored after STOP", a, 0);
        chk("R9 released after STOP", sda_oe, 0);
        bus_start();
        bus_stop();

        chk("R10 drive changed during SCL high", glitches, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule